// File: doc/BRIEF.md
# Two-Wire Control Register Bank Slave

This block is a serial slave on a two-wire bus that gives a host read and write access to a small bank of eight-bit control registers. Each register drives its own slice of a parallel output bus into the rest of the chip. Every register loads a known value at reset, so the chip works whether or not the host ever touches the bus. The slave's seven-bit address comes from a strap pin.

The fast system clock samples both bus lines through two-stage synchronizers and detects their edges. The block finds start, repeated-start and stop conditions and shifts every byte most significant bit first. Bit 7 of the command byte picks the access kind. When it is 1, the access goes to the single register whose offset is in bits [6:0]. When it is 0, the access is a block transfer starting at register 0. A block write begins with a byte count, which the slave accepts and discards. A block read begins with a fixed count of 09h.

The host starts the read phase with a repeated start and the read address. The host ends the read phase by not acknowledging the last byte. Clock stretching, packet error codes and bus timeouts are not part of this block.

Top module: `smb_regfile`

## Requirements
- R1: The slave acknowledges (drives SDA low during the ninth clock) the 8-bit write address D2h when addrSel is 0 and D4h when addrSel is 1, and the same address with bit 0 set for reads.
- R2: An address byte that does not match gets no acknowledge. SDA stays released and every later byte is ignored until the next start condition, with no register changing.
- R3: A write with command bit 7 = 1 stores the following data byte in the register at offset cmd[6:0]. The command byte and the data byte are both acknowledged.
- R4: A command with bit 7 = 1, then a repeated start and the read address, returns the register at offset cmd[6:0], most significant bit first.
- R5: A write with command bit 7 = 0 (block) discards the first data byte as the byte count. The bytes after it go to registers 0, 1, 2, ... in ascending order, and each one is acknowledged.
- R6: A block read (command bit 7 = 0) returns 09h first, then registers 0 to 8 in ascending order.
- R7: A stop after any complete data byte keeps every byte already written. Registers not reached keep their values.
- R8: After reset, register i holds A0h + i for i = 0..8. regOut carries register i on bits [8i+7:8i].
- R9: A host NACK after a read byte ends the read phase, and the slave releases SDA. The slave changes SDA only while SCL is low.
- R10: Offsets 9 to 127 ignore writes and read as 00h. regOut changes only when a data byte completes in a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaOe | output | 1 | Pulls SDA low when 1 |
| sdaOut | output | 1 | Data driven while sdaOe is 1, always 0 for open drain |
| addrSel | input | 1 | Address strap: 0 selects D2h, 1 selects D4h |
| regOut | output | 72 | Register bank contents, register i on bits [8i+7:8i] |

## Verification
Two functions can land on the same stretch of SCL. Once the command byte is acknowledged the slave sits in the write phase, so the SCL rise just before a repeated start is counted as a first data bit. The start condition then has to discard that partial byte while the pointer set by the command survives. Every byte read drives this case. The bench judges it by checking that no register on regOut moved and that the byte returned matches the bench model. A stop that follows the acknowledge of a data byte in the middle of a block is the second overlap of commit and termination. The bench checks that case by comparing the whole register bus against the model.

// File: rtl/smbrf_pkg.sv
package smbrf_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WR,
    ST_RD
  } busState_e;

  typedef struct packed {
    logic shiftRx;
    logic loadCmd;
    logic writeByte;
    logic loadTx;
    logic shiftTx;
  } dpCtl_t;

  function automatic logic [BYTE_W-1:0] regDefault(input int idx);
    return BYTE_W'(32'hA0 + idx);
  endfunction
endpackage

// File: rtl/smbrf_ctrl.sv
module smbrf_ctrl
  import smbrf_pkg::*;
#(
  parameter logic [6:0] ADDR_LO = 7'h69,
  parameter logic [6:0] ADDR_HI = 7'h6A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrSel,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  output dpCtl_t            ctl,
  output logic              sdaBit,
  output logic              sdaOe,
  output busState_e         state
);
  logic [1:0] sclSync, sdaSync;
  logic       sclD, sdaD;
  logic [3:0] bitCnt;
  logic       ackDrive, txActive, hostAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclD    <= sclSync[1];
      sdaD    <= sdaSync[1];
    end
  end

  logic sclNow, sdaNow, sclRise, sclFall, startCond, stopCond;
  assign sclNow    = sclSync[1];
  assign sdaNow    = sdaSync[1];
  assign sclRise   = sclNow & ~sclD;
  assign sclFall   = ~sclNow & sclD;
  assign startCond = sclNow & sclD & sdaD & ~sdaNow;
  assign stopCond  = sclNow & sclD & ~sdaD & sdaNow;
  assign sdaBit    = sdaNow;

  logic [6:0] myAddr;
  logic       addrOk, rxPhase;
  assign myAddr  = addrSel ? ADDR_HI : ADDR_LO;
  assign addrOk  = (rxByte[7:1] == myAddr);
  assign rxPhase = (state == ST_ADDR) || (state == ST_CMD) || (state == ST_WR);

  always_comb begin
    ctl = '0;
    if (!startCond && !stopCond) begin
      ctl.shiftRx   = sclRise && rxPhase && (bitCnt < 4'd8);
      ctl.loadCmd   = sclFall && (bitCnt == 4'd8) && (state == ST_CMD);
      ctl.writeByte = sclFall && (bitCnt == 4'd8) && (state == ST_WR);
      ctl.loadTx    = sclFall && (bitCnt == 4'd9) &&
                      (((state == ST_ADDR) && ackDrive && rxByte[0]) ||
                       ((state == ST_RD) && hostAck));
      ctl.shiftTx   = sclFall && (state == ST_RD) && txActive &&
                      (bitCnt >= 4'd1) && (bitCnt <= 4'd7);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
      hostAck  <= 1'b0;
    end else if (startCond) begin
      state    <= ST_ADDR;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
    end else if (stopCond) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
    end else if (state != ST_IDLE) begin
      if (sclRise) begin
        bitCnt <= bitCnt + 4'd1;
        if ((state == ST_RD) && (bitCnt == 4'd8)) hostAck <= ~sdaNow;
      end
      if (sclFall && (bitCnt == 4'd8)) begin
        if (state == ST_RD)                    txActive <= 1'b0;
        else if ((state != ST_ADDR) || addrOk) ackDrive <= 1'b1;
        else                                   state    <= ST_IDLE;
      end
      if (sclFall && (bitCnt == 4'd9)) begin
        bitCnt   <= '0;
        ackDrive <= 1'b0;
        case (state)
          ST_ADDR: begin
            if (rxByte[0]) begin
              state    <= ST_RD;
              txActive <= 1'b1;
            end else begin
              state <= ST_CMD;
            end
          end
          ST_CMD:  state <= ST_WR;
          ST_RD: begin
            if (hostAck) txActive <= 1'b1;
            else         state    <= ST_IDLE;
          end
          default: state <= state;
        endcase
      end
    end
  end

  assign sdaOe = ackDrive | (txActive & ~txMsb);
endmodule

// File: rtl/smbrf_dp.sv
module smbrf_dp
  import smbrf_pkg::*;
#(
  parameter int NUM_REGS = 9,
  parameter int PTR_W    = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCtl_t                     ctl,
  input  logic                       sdaBit,
  output logic [BYTE_W-1:0]          rxByte,
  output logic                       txMsb,
  output logic [NUM_REGS*BYTE_W-1:0] regOut
);
  localparam logic [BYTE_W-1:0] COUNT_BYTE = BYTE_W'(NUM_REGS);

  logic [PTR_W-1:0]  ptr;
  logic              cntPhase;
  logic [BYTE_W-1:0] txReg, rdData;

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (ptr == PTR_W'(i)) rdData = regOut[i*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte   <= '0;
      txReg    <= '0;
      ptr      <= '0;
      cntPhase <= 1'b0;
    end else begin
      if (ctl.shiftRx) rxByte <= {rxByte[BYTE_W-2:0], sdaBit};
      if (ctl.loadCmd) begin
        ptr      <= rxByte[7] ? rxByte[PTR_W-1:0] : '0;
        cntPhase <= ~rxByte[7];
      end
      if (ctl.writeByte) begin
        if (cntPhase) cntPhase <= 1'b0;
        else          ptr      <= ptr + 1'b1;
      end
      if (ctl.loadTx) begin
        if (cntPhase) begin
          txReg    <= COUNT_BYTE;
          cntPhase <= 1'b0;
        end else begin
          txReg <= rdData;
          ptr   <= ptr + 1'b1;
        end
      end else if (ctl.shiftTx) begin
        txReg <= {txReg[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign txMsb = txReg[BYTE_W-1];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regOut[g*BYTE_W +: BYTE_W] <= regDefault(g);
      else if (ctl.writeByte && !cntPhase && (ptr == PTR_W'(g)))
        regOut[g*BYTE_W +: BYTE_W] <= rxByte;
    end
  end
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smbrf_pkg::*;
#(
  parameter int         NUM_REGS = 9,
  parameter logic [6:0] ADDR_LO  = 7'h69,
  parameter logic [6:0] ADDR_HI  = 7'h6A
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  output logic                       sdaOe,
  output logic                       sdaOut,
  input  logic                       addrSel,
  output logic [NUM_REGS*BYTE_W-1:0] regOut
);
  dpCtl_t            ctl;
  logic              sdaBit, txMsb;
  logic [BYTE_W-1:0] rxByte;
  busState_e         busState;

  smbrf_ctrl #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrSel(addrSel),
    .rxByte(rxByte), .txMsb(txMsb), .ctl(ctl), .sdaBit(sdaBit),
    .sdaOe(sdaOe), .state(busState)
  );

  smbrf_dp #(.NUM_REGS(NUM_REGS), .PTR_W(7)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaBit(sdaBit),
    .rxByte(rxByte), .txMsb(txMsb), .regOut(regOut)
  );

  assign sdaOut = 1'b0;
endmodule

// File: rtl/smb_regfile_chk.sv
module smb_regfile_chk
  import smbrf_pkg::*;
#(
  parameter int NUM_REGS = 9
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       sclIn,
  input logic                       sdaOe,
  input logic [NUM_REGS*BYTE_W-1:0] regOut,
  input busState_e                  busState
);
  logic [NUM_REGS*BYTE_W-1:0] defVec;
  always_comb
    for (int i = 0; i < NUM_REGS; i++) defVec[i*BYTE_W +: BYTE_W] = regDefault(i);

  // R8: reset leaves the default bank on regOut
  p_reset_defaults_r8: assert property (@(posedge clk)
    !rstN |=> (regOut == defVec));

  // R10: the bank only moves after a cycle spent in the write phase
  p_regs_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busState) != ST_WR) |-> $stable(regOut));

  // R2: an ignored or finished transfer never pulls SDA
  p_idle_released_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busState == ST_IDLE) |-> !sdaOe);

  // R9: SDA drive changes only while SCL is low
  p_sda_change_scl_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);
endmodule

bind smb_regfile smb_regfile_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .regOut(regOut), .busState(busState)
);

// File: tb/tb_smb_regfile.sv
module tb_smb_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 16;
  localparam int QTR        = 6;
  localparam int NREG       = 9;
  localparam int WD_CYCLES  = 150000;

  // {offset, data, expected read}
  localparam logic [23:0] VEC [6] = '{
    {8'h00, 8'h3C, 8'h3C}, {8'h08, 8'hC3, 8'hC3}, {8'h04, 8'h00, 8'h00},
    {8'h02, 8'hFF, 8'hFF}, {8'h09, 8'h55, 8'h00}, {8'h7F, 8'hAA, 8'h00}
  };

  logic clk = 1'b0, rstN = 1'b0, addrSel = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, sdaOut;
  logic [NREG*8-1:0] regOut;
  wire  sdaLine = sdaM & ~sdaOe;

  int nChecks = 0, nErr = 0;
  logic [7:0] mdl [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_regfile dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .sdaOut(sdaOut), .addrSel(addrSel), .regOut(regOut)
  );

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [71:0] mdlVec();
    logic [71:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    if (!sclM) begin
      sdaM = 1'b1; wt(HALF); sclM = 1'b1; wt(HALF);
    end
    sdaM = 1'b0; wt(HALF); sclM = 1'b0; wt(QTR);
  endtask

  task automatic busStop();
    sdaM = 1'b0; wt(HALF); sclM = 1'b1; wt(HALF); sdaM = 1'b1; wt(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; wt(HALF); sclM = 1'b1; wt(HALF); sclM = 1'b0; wt(QTR);
    end
    sdaM = 1'b1; wt(HALF); sclM = 1'b1; wt(HALF/2);
    ack = ~sdaLine;
    wt(HALF/2); sclM = 1'b0; wt(QTR);
  endtask

  task automatic recvByte(input logic hostAckBit, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(HALF); sclM = 1'b1; wt(HALF/2);
      b[i] = sdaLine;
      wt(HALF/2); sclM = 1'b0; wt(QTR);
    end
    sdaM = ~hostAckBit; wt(HALF); sclM = 1'b1; wt(HALF); sclM = 1'b0; wt(QTR);
    sdaM = 1'b1;
  endtask

  function automatic logic [7:0] wAddr();
    return addrSel ? 8'hD4 : 8'hD2;
  endfunction

  task automatic byteWrite(input logic [7:0] off, input logic [7:0] data);
    logic a;
    busStart();
    sendByte(wAddr(), a);           chk("R1 write address ack", a, 1);
    sendByte(8'h80 | off, a);       chk("R3 command ack", a, 1);
    sendByte(data, a);              chk("R3 data ack", a, 1);
    busStop();
    if (off < NREG) mdl[off] = data;
  endtask

  task automatic byteRead(input logic [7:0] off, output logic [7:0] d);
    logic a;
    busStart();
    sendByte(wAddr(), a);           chk("R1 write address ack", a, 1);
    sendByte(8'h80 | off, a);       chk("R4 command ack", a, 1);
    busStart();
    sendByte(wAddr() | 8'h01, a);   chk("R1 read address ack", a, 1);
    recvByte(1'b0, d);
    chk("R9 SDA released after host NACK", sdaOe, 0);
    busStop();
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic a;
    for (int i = 0; i < NREG; i++) mdl[i] = 8'(8'hA0 + i);
    wt(5);
    chk("R8 defaults during reset", regOut, mdlVec());
    rstN = 1'b1;
    wt(5);
    chk("R8 defaults after reset", regOut, mdlVec());
    chk("R8 SDA released after reset", sdaOe, 0);

    byteRead(8'h05, d);
    chk("R4 byte read of default", d, 8'hA5);

    for (int v = 0; v < 6; v++) begin
      byteWrite(VEC[v][23:16], VEC[v][15:8]);
      chk("R3 R10 bank after byte write", regOut, mdlVec());
      byteRead(VEC[v][23:16], d);
      chk("R4 R10 byte read back", d, VEC[v][7:0]);
    end

    busStart();
    sendByte(wAddr(), a);  chk("R1 block write address ack", a, 1);
    sendByte(8'h00, a);    chk("R5 block command ack", a, 1);
    sendByte(8'h09, a);    chk("R5 byte count ack", a, 1);
    for (int i = 0; i < NREG; i++) begin
      sendByte(8'(8'h11 * (i + 1)), a);
      chk("R5 block data ack", a, 1);
      mdl[i] = 8'(8'h11 * (i + 1));
    end
    busStop();
    chk("R5 bank after block write", regOut, mdlVec());

    busStart();
    sendByte(wAddr(), a);
    sendByte(8'h00, a);
    busStart();
    sendByte(wAddr() | 8'h01, a);  chk("R1 block read address ack", a, 1);
    recvByte(1'b1, d);             chk("R6 block count byte", d, 8'h09);
    for (int i = 0; i < NREG; i++) begin
      recvByte(i != NREG - 1, d);
      chk("R6 block read data", d, mdl[i]);
    end
    chk("R9 SDA released after final NACK", sdaOe, 0);
    busStop();

    busStart();
    sendByte(wAddr(), a);
    sendByte(8'h00, a);
    sendByte(8'h09, a);
    for (int i = 0; i < 3; i++) begin
      sendByte(8'(8'hE0 + i), a);
      mdl[i] = 8'(8'hE0 + i);
    end
    busStop();
    chk("R7 partial block kept, rest unchanged", regOut, mdlVec());

    busStart();
    sendByte(8'hD4, a);    chk("R2 foreign address NACK", a, 0);
    sendByte(8'h80, a);    chk("R2 later byte not acked", a, 0);
    sendByte(8'h77, a);    chk("R2 data byte not acked", a, 0);
    chk("R2 SDA released while ignoring", sdaOe, 0);
    busStop();
    chk("R2 bank unchanged after ignored transfer", regOut, mdlVec());

    addrSel = 1'b1;
    wt(4);
    busStart();
    sendByte(8'hD2, a);    chk("R1 D2h ignored with strap high", a, 0);
    busStop();
    byteWrite(8'h03, 8'h5A);
    chk("R1 bank after write at D4h", regOut, mdlVec());
    byteRead(8'h03, d);
    chk("R1 R4 read at D4h", d, 8'h5A);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule